// File: doc/BRIEF.md
# Parallel Flash Page-Write Programmer

This block loads a byte-wide parallel flash that is written page by page. A host hands it one command at a time over a valid/ready handshake. There are four commands:

- **Erase** wipes the whole array.
- **Program** accepts a 32-bit word and lays it into the array as four bytes, starting from address zero and moving upward.
- **Flush** closes a partly filled page.
- **No-op** does nothing.

The block generates every bus cycle itself: the write-protection unlock that must open each page, the chip-erase command string, and the data bytes.

The flash runs its internal program and erase operations without being polled. The block therefore waits out fixed, cycle-counted intervals. One interval follows each completed page and one follows an erase. The host sees ready low for the whole of any command sequence and any wait.

Both intervals are parameters given in clock cycles. The defaults, 625,000 and 2,500,000 cycles, correspond to 5 ms and 20 ms at 125 MHz. `PAGE_BYTES` must be a power of two and a multiple of four. The default array is 2048 pages of 128 bytes, giving an 18-bit address.

Top module: `flash_page_prog`

## Requirements
- R1: After reset, `cmd_ready` is 1 and `fl_cs`/`fl_we` are 0. The first programmed word goes to byte address 0 and is preceded by the unlock sequence.
- R2: Each bus write lasts exactly one clock with `fl_cs` and `fl_we` both 1. It is always followed by at least one clock with both at 0.
- R3: An accepted erase (`cmd_op` = 2'b01) produces these six writes, in this order: 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x10@0x5555. The block then stays busy for `T_ERASE` cycles, and the next programmed byte goes to address 0.
- R4: An accepted program command (`cmd_op` = 2'b00) writes `cmd_word` as four bytes at consecutive ascending addresses, bits [7:0] first and bits [31:24] last.
- R5: Whenever the next byte address has in-page offset 0, three unlock writes come before that byte, in this order: 0xAA@0x5555, 0x55@0x2AAA, 0xA0@0x5555.
- R6: After the byte at in-page offset `PAGE_BYTES`-1 is written, `cmd_ready` stays 0 for a further `T_PAGE` cycles after that byte's idle clock.
- R7: An accepted flush (`cmd_op` = 2'b10) at a nonzero in-page offset makes no bus writes and holds `cmd_ready` at 0 for `T_PAGE` cycles. The next word then starts at the following page boundary, with unlock.
- R8: A flush at in-page offset 0, or the code 2'b11, is accepted without bus activity, and `cmd_ready` stays 1 in the next cycle.
- R9: `cmd_ready` is 0 throughout any write sequence or wait, and the bus is idle whenever `cmd_ready` is 1. A command held valid while busy is taken exactly once, on the first ready cycle.
- R10: The first bus write of a command appears in the cycle after acceptance. Writes follow one another every second cycle, and `cmd_ready` returns in the cycle after the last idle clock or wait cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Host command present |
| cmd_op | input | 2 | 00 program, 01 erase, 10 flush, 11 no-op |
| cmd_word | input | 32 | Data word for the program command |
| cmd_ready | output | 1 | Block idle; command taken when valid and ready |
| fl_addr | output | ADDR_W | Flash byte address |
| fl_data | output | 8 | Flash write data |
| fl_cs | output | 1 | Flash chip select, active high |
| fl_we | output | 1 | Flash write strobe, active high |

## Verification
The hardest situation to reach is a page boundary that falls inside a stream of back-to-back commands. At that point the page wait and the unlock for the next page must both appear, in the right cycles.

The bench sends a full page of words without gaps, keeping `cmd_valid` high through every busy stretch. It then sends a short run of words, a flush, and a word at the skipped-to boundary. The behavioural model expands each accepted command into a queue of expected per-cycle bus states, so a wait that is one cycle off, or an unlock that is missing or misplaced, shows up as a mismatch at that exact clock.

// File: rtl/fpp_pkg.sv
package fpp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CMD,
        ST_DATA,
        ST_WAIT
    } fpp_state_t;

    localparam logic [1:0] OP_PROG  = 2'b00;
    localparam logic [1:0] OP_ERASE = 2'b01;
    localparam logic [1:0] OP_FLUSH = 2'b10;

    typedef struct packed {
        logic [15:0] addr;
        logic [7:0]  data;
    } bus_wr_t;

    // Command-string entry i: unlock string (3 writes) or erase string (6 writes).
    function automatic bus_wr_t seq_entry(input logic erase, input logic [2:0] i);
        bus_wr_t r;
        if (!erase) begin
            case (i)
                3'd0:    r = '{addr: 16'h5555, data: 8'hAA};
                3'd1:    r = '{addr: 16'h2AAA, data: 8'h55};
                default: r = '{addr: 16'h5555, data: 8'hA0};
            endcase
        end else begin
            case (i)
                3'd0, 3'd3: r = '{addr: 16'h5555, data: 8'hAA};
                3'd1, 3'd4: r = '{addr: 16'h2AAA, data: 8'h55};
                3'd2:       r = '{addr: 16'h5555, data: 8'h80};
                default:    r = '{addr: 16'h5555, data: 8'h10};
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/fpp_timer.sv
module fpp_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          done
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)             cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/fpp_addr_ctr.sv
module fpp_addr_ctr #(
    parameter int PG_W  = 11,
    parameter int OFF_W = 7
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clr,
    input  logic                  inc,
    input  logic                  skip,
    output logic [PG_W+OFF_W-1:0] addr,
    output logic                  off_zero,
    output logic                  off_last
);
    logic [PG_W-1:0]  page;
    logic [OFF_W-1:0] off;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            page <= '0;
            off  <= '0;
        end else if (skip) begin
            page <= page + 1'b1;
            off  <= '0;
        end else if (inc) begin
            {page, off} <= {page, off} + 1'b1;
        end
    end

    assign addr     = {page, off};
    assign off_zero = (off == '0);
    assign off_last = (off == '1);
endmodule

// File: rtl/flash_page_prog.sv
module flash_page_prog
    import fpp_pkg::*;
#(
    parameter int ADDR_W     = 18,
    parameter int PAGE_BYTES = 128,
    parameter int T_PAGE     = 625000,
    parameter int T_ERASE    = 2500000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [31:0]       cmd_word,
    output logic              cmd_ready,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [7:0]        fl_data,
    output logic              fl_cs,
    output logic              fl_we
);
    localparam int OFF_W = $clog2(PAGE_BYTES);
    localparam int PG_W  = ADDR_W - OFF_W;
    localparam int T_MAX = (T_PAGE > T_ERASE) ? T_PAGE : T_ERASE;
    localparam int TW    = $clog2(T_MAX + 1);

    fpp_state_t        st;
    logic [2:0]        idx;
    logic              gap;
    logic              is_erase;
    logic [31:0]       word_q;

    logic              accept, seq_last;
    logic              ctr_clr, ctr_inc, ctr_skip;
    logic              tmr_load, tmr_done;
    logic [TW-1:0]     tmr_val;
    logic [ADDR_W-1:0] cur_addr;
    logic              off_zero, off_last;
    bus_wr_t           ent;

    assign accept    = cmd_valid && (st == ST_IDLE);
    assign cmd_ready = (st == ST_IDLE);
    assign seq_last  = is_erase ? (idx == 3'd5) : (idx == 3'd2);
    assign ent       = seq_entry(is_erase, idx);

    fpp_addr_ctr #(.PG_W(PG_W), .OFF_W(OFF_W)) u_ctr (
        .clk(clk), .rst(rst), .clr(ctr_clr), .inc(ctr_inc), .skip(ctr_skip),
        .addr(cur_addr), .off_zero(off_zero), .off_last(off_last)
    );

    fpp_timer #(.TW(TW)) u_tmr (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
    );

    always_comb begin
        ctr_clr  = 1'b0;
        ctr_inc  = 1'b0;
        ctr_skip = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = TW'(T_PAGE - 1);
        fl_cs    = 1'b0;
        fl_we    = 1'b0;
        fl_addr  = '0;
        fl_data  = '0;
        case (st)
            ST_IDLE: begin
                if (accept && cmd_op == OP_ERASE) ctr_clr = 1'b1;
                if (accept && cmd_op == OP_FLUSH && !off_zero) begin
                    ctr_skip = 1'b1;
                    tmr_load = 1'b1;
                end
            end
            ST_CMD: begin
                if (!gap) begin
                    fl_cs   = 1'b1;
                    fl_we   = 1'b1;
                    fl_addr = ADDR_W'(ent.addr);
                    fl_data = ent.data;
                end else if (seq_last && is_erase) begin
                    tmr_load = 1'b1;
                    tmr_val  = TW'(T_ERASE - 1);
                end
            end
            ST_DATA: begin
                if (!gap) begin
                    fl_cs   = 1'b1;
                    fl_we   = 1'b1;
                    fl_addr = cur_addr;
                    fl_data = word_q[7:0];
                end else begin
                    ctr_inc = 1'b1;
                    if (idx == 3'd3 && off_last) tmr_load = 1'b1;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            idx      <= '0;
            gap      <= 1'b0;
            is_erase <= 1'b0;
            word_q   <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (accept) begin
                        idx <= '0;
                        gap <= 1'b0;
                        case (cmd_op)
                            OP_ERASE: begin
                                is_erase <= 1'b1;
                                st       <= ST_CMD;
                            end
                            OP_PROG: begin
                                is_erase <= 1'b0;
                                word_q   <= cmd_word;
                                st       <= off_zero ? ST_CMD : ST_DATA;
                            end
                            OP_FLUSH: begin
                                if (!off_zero) st <= ST_WAIT;
                            end
                            default: ;
                        endcase
                    end
                end
                ST_CMD: begin
                    gap <= !gap;
                    if (gap) begin
                        if (seq_last) begin
                            idx <= '0;
                            st  <= is_erase ? ST_WAIT : ST_DATA;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                ST_DATA: begin
                    gap <= !gap;
                    if (gap) begin
                        word_q <= word_q >> 8;
                        if (idx == 3'd3) begin
                            idx <= '0;
                            st  <= off_last ? ST_WAIT : ST_IDLE;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                ST_WAIT: begin
                    if (tmr_done) st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/fpp_checker.sv
module fpp_checker #(
    parameter int ADDR_W = 18
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_valid,
    input logic [1:0]        cmd_op,
    input logic              cmd_ready,
    input logic [ADDR_W-1:0] fl_addr,
    input logic [7:0]        fl_data,
    input logic              fl_cs,
    input logic              fl_we
);
    // R2: a write strobe is always followed by an idle bus clock
    a_r2_idle_after_write: assert property (@(posedge clk) disable iff (rst)
        fl_we |=> (!fl_we && !fl_cs));

    // R9: no bus activity while the block offers ready
    a_r9_quiet_when_ready: assert property (@(posedge clk) disable iff (rst)
        cmd_ready |-> (!fl_cs && !fl_we));

    // R3: accepted erase opens with 0xAA at 0x5555 in the next cycle
    a_r3_erase_opens: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready && cmd_op == 2'b01) |=>
        (fl_we && fl_cs && fl_addr == ADDR_W'(16'h5555) && fl_data == 8'hAA && !cmd_ready));

    // R10: accepted program makes a write in the next cycle
    a_r10_prog_starts: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready && cmd_op == 2'b00) |=> (fl_we && !cmd_ready));

    // R8: the no-op code leaves the block ready
    a_r8_nop_stays_ready: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready && cmd_op == 2'b11) |=> (cmd_ready && !fl_cs));

    // R5: the unlock tail is followed by a data write two cycles later
    a_r5_unlock_then_data: assert property (@(posedge clk) disable iff (rst)
        (fl_we && fl_addr == ADDR_W'(16'h5555) && fl_data == 8'hA0) |=> ##1 fl_we);
endmodule

bind flash_page_prog fpp_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_ready(cmd_ready), .fl_addr(fl_addr), .fl_data(fl_data),
    .fl_cs(fl_cs), .fl_we(fl_we)
);

// File: tb/sim_flash_page_prog.sv
`timescale 1ns/1ps
module sim_flash_page_prog;
    localparam int AW  = 18;
    localparam int PB  = 128;
    localparam int TP  = 40;
    localparam int TE  = 90;
    localparam int LIM = 150000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_op = 2'b00;
    logic [31:0]   cmd_word = '0;
    logic          cmd_ready;
    logic [AW-1:0] fl_addr;
    logic [7:0]    fl_data;
    logic          fl_cs, fl_we;

    always #4 clk = ~clk;

    flash_page_prog #(.ADDR_W(AW), .PAGE_BYTES(PB), .T_PAGE(TP), .T_ERASE(TE)) u0 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_word(cmd_word),
        .cmd_ready(cmd_ready), .fl_addr(fl_addr), .fl_data(fl_data), .fl_cs(fl_cs), .fl_we(fl_we)
    );

    typedef struct {
        bit            cs;
        logic [AW-1:0] addr;
        logic [7:0]    data;
        string         tag;
    } exp_t;

    exp_t q[$];
    int   m_addr  = 0;
    int   acc_cnt = 0;
    int   n_chk   = 0;
    int   n_err   = 0;
    int   cyc     = 0;
    bit   cmp_on  = 0;

    task automatic chk(input bit ok, input string tag, input string msg);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: %s", tag, msg);
        end
    endtask

    function automatic void push_wr(input int a, input int d, input string tag);
        exp_t e;
        e.cs = 1; e.addr = AW'(a); e.data = 8'(d); e.tag = tag;
        q.push_back(e);
        e.cs = 0; e.addr = '0; e.data = '0; e.tag = "R2";
        q.push_back(e);
    endfunction

    function automatic void push_wait(input int n, input string tag);
        exp_t e;
        e.cs = 0; e.addr = '0; e.data = '0; e.tag = tag;
        for (int k = 0; k < n; k++) q.push_back(e);
    endfunction

    function automatic void model_cmd(input logic [1:0] op, input logic [31:0] w);
        case (op)
            2'b01: begin
                push_wr('h5555, 'hAA, "R3"); push_wr('h2AAA, 'h55, "R3");
                push_wr('h5555, 'h80, "R3"); push_wr('h5555, 'hAA, "R3");
                push_wr('h2AAA, 'h55, "R3"); push_wr('h5555, 'h10, "R3");
                push_wait(TE, "R3");
                m_addr = 0;
            end
            2'b00: begin
                if (m_addr % PB == 0) begin
                    push_wr('h5555, 'hAA, "R5"); push_wr('h2AAA, 'h55, "R5");
                    push_wr('h5555, 'hA0, "R5");
                end
                for (int b = 0; b < 4; b++) begin
                    push_wr(m_addr, int'((w >> (8 * b)) & 32'hFF), "R4");
                    m_addr = (m_addr + 1) % (1 << AW);
                end
                if (m_addr % PB == 0) push_wait(TP, "R6");
            end
            2'b10: begin
                if (m_addr % PB != 0) begin
                    push_wait(TP, "R7");
                    m_addr = ((m_addr / PB + 1) * PB) % (1 << AW);
                end
            end
            default: ;
        endcase
    endfunction

    // Reference model: advances one cycle per clock edge
    always @(posedge clk) begin
        if (!rst) begin
            bit acc;
            acc = cmd_valid && (q.size() == 0);
            if (q.size() != 0) void'(q.pop_front());
            if (acc) begin
                model_cmd(cmd_op, cmd_word);
                acc_cnt++;
            end
        end
    end

    // Cycle-by-cycle comparison, away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (cmp_on) begin
            if (q.size() != 0) begin
                exp_t e;
                e = q[0];
                chk(cmd_ready == 1'b0, "R9",
                    $sformatf("ready act=%0b exp=0 (step %s)", cmd_ready, e.tag));
                chk(fl_cs == e.cs && fl_we == e.cs, e.tag,
                    $sformatf("cs/we act=%0b/%0b exp=%0b", fl_cs, fl_we, e.cs));
                if (e.cs)
                    chk(fl_addr == e.addr && fl_data == e.data, e.tag,
                        $sformatf("addr/data act=%h/%h exp=%h/%h", fl_addr, fl_data, e.addr, e.data));
            end else begin
                chk(cmd_ready == 1'b1 && !fl_cs && !fl_we, "R10",
                    $sformatf("idle ready/cs/we act=%0b/%0b/%0b exp=1/0/0", cmd_ready, fl_cs, fl_we));
            end
        end
        if (cyc > LIM) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: act=%0d cycles exp<=%0d", cyc, LIM);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    task automatic send(input logic [1:0] op, input logic [31:0] w);
        int c0;
        @(negedge clk);
        c0 = acc_cnt;
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_word  = w;
        while (acc_cnt == c0) @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic drain();
        while (q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(cmd_ready == 1'b1 && !fl_cs && !fl_we, "R1",
            $sformatf("reset ready/cs/we act=%0b/%0b/%0b exp=1/0/0", cmd_ready, fl_cs, fl_we));
        rst = 1'b0;
        cmp_on = 1'b1;

        // R1: first word after reset lands at address 0 with unlock
        send(2'b00, 32'h1122_3344);
        // R3: erase, issued while busy (R9: held valid taken once)
        send(2'b01, 32'h0);
        // R6: a full page back to back
        for (int i = 0; i < PB / 4; i++)
            send(2'b00, 32'h0102_0304 * (i + 1) ^ 32'hA5C3_5A3C);
        // R7: partial page then flush, next word at next page boundary
        send(2'b00, 32'hDEAD_BEEF);
        send(2'b00, 32'hCAFE_F00D);
        send(2'b00, 32'h0BAD_F00D);
        send(2'b10, 32'h0);
        send(2'b00, 32'h7766_5544);
        send(2'b10, 32'h0);
        drain();
        // R8: flush at offset zero and the no-op code
        send(2'b10, 32'h0);
        chk(cmd_ready == 1'b1 && !fl_cs, "R8",
            $sformatf("flush@0 ready/cs act=%0b/%0b exp=1/0", cmd_ready, fl_cs));
        send(2'b11, 32'hFFFF_FFFF);
        chk(cmd_ready == 1'b1 && !fl_cs, "R8",
            $sformatf("no-op ready/cs act=%0b/%0b exp=1/0", cmd_ready, fl_cs));
        // R3: erase returns programming to address 0
        send(2'b01, 32'h0);
        send(2'b00, 32'h89AB_CDEF);
        drain();

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule